// File: doc/BRIEF.md
# Fetch Address Steering Unit

This unit owns the fetch address of a five-stage, in-order, 32-bit pipeline. On every clock edge it does one of three things. It steps the address forward by one word, keeps it where it is, or loads a redirect target. It also tells the pipeline registers which of their younger instructions must be turned into bubbles.

Redirects come from two stages. Direct jumps are recognised in decode, and only the single instruction fetched behind them is lost. Register jumps and conditional branches are only settled in execute, so both younger instructions are cleared. When both stages ask in the same cycle, the older instruction in execute wins. A stall request from the hazard logic freezes the address, but a redirect still goes through. The address register keeps only the 30 word-index bits.

Top module: `fetch_steer`

## Requirements
- R1: While rst_ni is low, fetch_pc_o equals the RESET_PC parameter, and flush_ifid_o and flush_idex_o are both high.
- R2: With no redirect and hold_i low, pc_we_o and both flush outputs are low, and fetch_pc_o rises by 4 at each rising clock edge.
- R3: With no redirect and hold_i high, fetch_pc_o keeps its value across the edge, and no flush is raised.
- R4: A decode-stage instruction whose opcode bits 31:26 are 6'h02 or 6'h03 raises pc_we_o and flush_ifid_o only. The next fetch_pc_o is {(id_pc_i+4)[31:28], id_instr_i[25:0], 2'b00}.
- R5: An execute-stage instruction with opcode 6'h00 and function bits 5:0 equal to 6'h08 raises pc_we_o, flush_ifid_o and flush_idex_o. The next fetch_pc_o is ex_jr_tgt_i with bits 1:0 cleared.
- R6: Opcode 6'h04 in execute is taken when ex_opa_i equals ex_opb_i. Opcode 6'h05 in execute is taken when they differ. A taken branch raises all three outputs and loads ex_pc_i + 4 + (sign-extended bits 15:0 shifted left by 2).
- R7: Opcode 6'h07 in execute is taken only when ex_opa_i, read as a signed number, is greater than zero. A zero or negative value is not taken.
- R8: A branch that is not taken raises no flush and no pc_we_o, and sequential stepping continues.
- R9: When an execute-stage redirect and a decode-stage jump are present in the same cycle, the execute-stage target is loaded and both flushes are raised.
- R10: A redirect loads its target even while hold_i is high.
- R11: Bits 1:0 of fetch_pc_o are always zero, including after a register jump to an unaligned value.
- R12: Other instructions cause no redirect. This covers a jump opcode in execute, a branch opcode in decode, and other function codes under opcode 6'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_i | input | 1 | Stall request from the hazard logic |
| id_instr_i | input | 32 | Instruction word in decode |
| id_pc_i | input | 32 | Address of the decode instruction |
| ex_instr_i | input | 32 | Instruction word in execute |
| ex_pc_i | input | 32 | Address of the execute instruction |
| ex_opa_i | input | 32 | First branch compare operand |
| ex_opb_i | input | 32 | Second branch compare operand |
| ex_jr_tgt_i | input | 32 | Register operand of a register jump |
| fetch_pc_o | output | 32 | Current fetch address |
| pc_we_o | output | 1 | A redirect target is loaded at the next edge |
| flush_ifid_o | output | 1 | Clear the IF/ID register at the next edge |
| flush_idex_o | output | 1 | Clear the ID/EX register at the next edge |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is an execute-stage redirect and a decode-stage jump. The second pair is a redirect and a stall. The vector table places a jump in decode together with a taken branch in execute, and then together with a branch that is not taken. It also puts hold_i high while a register jump or a decode jump is present. Each case is judged by the loaded address and by which flushes are raised: the execute target must win, and the redirect must win over the stall.

// File: rtl/fetch_steer_pkg.sv
package fetch_steer_pkg;
  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_J       = 6'h02;
  localparam logic [5:0] OP_JAL     = 6'h03;
  localparam logic [5:0] OP_BEQ     = 6'h04;
  localparam logic [5:0] OP_BNE     = 6'h05;
  localparam logic [5:0] OP_BGTZ    = 6'h07;
  localparam logic [5:0] FN_JR      = 6'h08;

  typedef enum logic [1:0] {
    SRC_SEQ,
    SRC_IDJ,
    SRC_EXR
  } steer_src_e;
endpackage

// File: rtl/id_jump_dec.sv
module id_jump_dec
  import fetch_steer_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] instr_i,
  input  logic [XLEN-1:0] pc_i,
  output logic            take_o,
  output logic [XLEN-1:0] tgt_o
);
  localparam int IDXW = 26;
  localparam int HIW  = XLEN - IDXW - 2;

  logic [XLEN-1:0] pc_inc;
  logic [5:0]      opc;

  assign opc    = instr_i[31:26];
  assign pc_inc = pc_i + XLEN'(4);
  assign take_o = (opc == OP_J) || (opc == OP_JAL);
  assign tgt_o  = {pc_inc[XLEN-1 -: HIW], instr_i[IDXW-1:0], 2'b00};
endmodule

// File: rtl/ex_resolve.sv
module ex_resolve
  import fetch_steer_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] instr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  input  logic [XLEN-1:0] jr_i,
  output logic            take_o,
  output logic [XLEN-1:0] tgt_o
);
  localparam int OFFW = 16;
  localparam int SEXW = XLEN - OFFW - 2;

  logic [5:0]      opc;
  logic            is_jr, is_br, br_hit, eq, gtz;
  logic [XLEN-1:0] br_tgt, off;

  assign opc   = instr_i[31:26];
  assign eq    = (opa_i == opb_i);
  assign gtz   = !opa_i[XLEN-1] && (|opa_i);
  assign is_jr = (opc == OP_SPECIAL) && (instr_i[5:0] == FN_JR);

  always_comb begin
    is_br  = 1'b1;
    br_hit = 1'b0;
    unique case (opc)
      OP_BEQ:  br_hit = eq;
      OP_BNE:  br_hit = !eq;
      OP_BGTZ: br_hit = gtz;
      default: is_br  = 1'b0;
    endcase
  end

  assign off    = {{SEXW{instr_i[OFFW-1]}}, instr_i[OFFW-1:0], 2'b00};
  assign br_tgt = pc_i + XLEN'(4) + off;
  assign take_o = is_jr || (is_br && br_hit);
  assign tgt_o  = is_jr ? jr_i : br_tgt;
endmodule

// File: rtl/pc_word_reg.sv
module pc_word_reg #(
  parameter int              PCW      = 30,
  parameter logic [PCW-1:0]  RESET_WI = '0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           hold_i,
  input  logic           we_i,
  input  logic [PCW-1:0] load_i,
  output logic [PCW-1:0] wi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wi_o <= RESET_WI;
    else if (we_i)    wi_o <= load_i;   // redirect beats hold
    else if (!hold_i) wi_o <= wi_o + PCW'(1);
  end
endmodule

// File: rtl/fetch_steer.sv
module fetch_steer
  import fetch_steer_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0000_3000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hold_i,
  input  logic [XLEN-1:0] id_instr_i,
  input  logic [XLEN-1:0] id_pc_i,
  input  logic [XLEN-1:0] ex_instr_i,
  input  logic [XLEN-1:0] ex_pc_i,
  input  logic [XLEN-1:0] ex_opa_i,
  input  logic [XLEN-1:0] ex_opb_i,
  input  logic [XLEN-1:0] ex_jr_tgt_i,
  output logic [XLEN-1:0] fetch_pc_o,
  output logic            pc_we_o,
  output logic            flush_ifid_o,
  output logic            flush_idex_o
);
  localparam int PCW = XLEN - 2;

  logic            id_take, ex_take;
  logic [XLEN-1:0] id_tgt, ex_tgt, npc;
  logic [PCW-1:0]  wi;
  steer_src_e      src;

  id_jump_dec #(.XLEN(XLEN)) u_idj (
    .instr_i(id_instr_i), .pc_i(id_pc_i), .take_o(id_take), .tgt_o(id_tgt)
  );

  ex_resolve #(.XLEN(XLEN)) u_exr (
    .instr_i(ex_instr_i), .pc_i(ex_pc_i), .opa_i(ex_opa_i), .opb_i(ex_opb_i),
    .jr_i(ex_jr_tgt_i), .take_o(ex_take), .tgt_o(ex_tgt)
  );

  // older instruction in EX has priority
  always_comb begin
    if (ex_take)      src = SRC_EXR;
    else if (id_take) src = SRC_IDJ;
    else              src = SRC_SEQ;
  end

  always_comb begin
    unique case (src)
      SRC_EXR: npc = ex_tgt;
      SRC_IDJ: npc = id_tgt;
      default: npc = fetch_pc_o + XLEN'(4);
    endcase
  end

  pc_word_reg #(.PCW(PCW), .RESET_WI(RESET_PC[XLEN-1:2])) u_pc (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold_i), .we_i(pc_we_o),
    .load_i(npc[XLEN-1:2]), .wi_o(wi)
  );

  assign fetch_pc_o   = {wi, 2'b00};
  assign pc_we_o      = (src != SRC_SEQ);
  assign flush_ifid_o = !rst_ni || pc_we_o;
  assign flush_idex_o = !rst_ni || (src == SRC_EXR);
endmodule

// File: rtl/fetch_steer_chk.sv
module fetch_steer_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            hold_i,
  input logic            pc_we_o,
  input logic            flush_ifid_o,
  input logic            flush_idex_o,
  input logic [XLEN-1:0] fetch_pc_o,
  input logic [XLEN-1:0] npc_i
);
  localparam logic [XLEN-1:0] WMASK = ~XLEN'(3);

  p_seq_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pc_we_o && !hold_i) |=> fetch_pc_o == $past(fetch_pc_o) + XLEN'(4));

  p_hold_freeze_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !pc_we_o) |=> $stable(fetch_pc_o));

  p_load_target_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |=> fetch_pc_o == ($past(npc_i) & WMASK));

  p_idex_flush_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_idex_o |-> flush_ifid_o);

  p_flush_has_redirect_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_ifid_o |-> pc_we_o);
endmodule

bind fetch_steer fetch_steer_chk #(.XLEN(XLEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold_i), .pc_we_o(pc_we_o),
  .flush_ifid_o(flush_ifid_o), .flush_idex_o(flush_idex_o),
  .fetch_pc_o(fetch_pc_o), .npc_i(npc)
);

// File: tb/fetch_steer_tb_top.sv
module fetch_steer_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] RST_PC     = 32'h0000_3000;

  localparam logic [2:0] K_SEQ = 3'd0, K_HLD = 3'd1, K_IDJ = 3'd2, K_BR = 3'd3, K_JR = 3'd4;

  localparam logic [31:0] NOP  = 32'h0000_0000;
  localparam logic [31:0] ALU  = 32'h0022_1820;
  localparam logic [31:0] JMP  = 32'h0800_0100;
  localparam logic [31:0] JAL  = 32'h0FFF_FFFF;
  localparam logic [31:0] JRG  = 32'h03E0_0008;
  localparam logic [31:0] BEQF = 32'h1000_0010;
  localparam logic [31:0] BEQB = 32'h1000_FFFE;
  localparam logic [31:0] BNE4 = 32'h1400_0004;
  localparam logic [31:0] BGT8 = 32'h1C00_0008;

  typedef struct packed {
    logic [31:0] tag;
    logic [31:0] id_ins;
    logic [31:0] id_pc;
    logic [31:0] ex_ins;
    logic [31:0] ex_pc;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] jr;
    logic        hold;
    logic [2:0]  kind;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{"R2",  NOP,  32'h100,       NOP,  32'h0FC,  32'd0, 32'd0, 32'd0,          1'b0, K_SEQ},
    '{"R2",  ALU,  32'h104,       ALU,  32'h100,  32'd3, 32'd4, 32'd0,          1'b0, K_SEQ},
    '{"R3",  NOP,  32'h108,       NOP,  32'h104,  32'd0, 32'd0, 32'd0,          1'b1, K_HLD},
    '{"R4",  JMP,  32'h9000_0010, NOP,  32'h0,    32'd0, 32'd0, 32'd0,          1'b0, K_IDJ},
    '{"R4",  JAL,  32'h1FFF_FFFC, NOP,  32'h0,    32'd0, 32'd0, 32'd0,          1'b0, K_IDJ},
    '{"R5",  NOP,  32'h0,         JRG,  32'h200,  32'd0, 32'd0, 32'h0040_1234,  1'b0, K_JR},
    '{"R11", NOP,  32'h0,         JRG,  32'h200,  32'd0, 32'd0, 32'h0040_1237,  1'b0, K_JR},
    '{"R6",  NOP,  32'h0,         BEQF, 32'h400,  32'd5, 32'd5, 32'd0,          1'b0, K_BR},
    '{"R8",  NOP,  32'h0,         BEQF, 32'h400,  32'd5, 32'd6, 32'd0,          1'b0, K_SEQ},
    '{"R6",  NOP,  32'h0,         BNE4, 32'h800,  32'd1, 32'd2, 32'd0,          1'b0, K_BR},
    '{"R8",  NOP,  32'h0,         BNE4, 32'h800,  32'd7, 32'd7, 32'd0,          1'b0, K_SEQ},
    '{"R6",  NOP,  32'h0,         BEQB, 32'h1000, 32'd0, 32'd0, 32'd0,          1'b0, K_BR},
    '{"R7",  NOP,  32'h0,         BGT8, 32'h600,  32'd1, 32'd0, 32'd0,          1'b0, K_BR},
    '{"R7",  NOP,  32'h0,         BGT8, 32'h600,  32'd0, 32'd0, 32'd0,          1'b0, K_SEQ},
    '{"R7",  NOP,  32'h0,         BGT8, 32'h600,  32'h8000_0000, 32'd0, 32'd0,  1'b0, K_SEQ},
    '{"R9",  JMP,  32'h9000_0010, BEQF, 32'h400,  32'd9, 32'd9, 32'd0,          1'b0, K_BR},
    '{"R9",  JMP,  32'h9000_0010, BEQF, 32'h400,  32'd9, 32'd8, 32'd0,          1'b0, K_IDJ},
    '{"R10", NOP,  32'h0,         JRG,  32'h200,  32'd0, 32'd0, 32'h0000_5000,  1'b1, K_JR},
    '{"R10", JAL,  32'h2000_0040, NOP,  32'h0,    32'd0, 32'd0, 32'd0,          1'b1, K_IDJ},
    '{"R3",  NOP,  32'h0,         BEQF, 32'h400,  32'd1, 32'd2, 32'd0,          1'b1, K_HLD},
    '{"R12", BEQF, 32'h300,       JMP,  32'h2FC,  32'd4, 32'd4, 32'd0,          1'b0, K_SEQ},
    '{"R12", NOP,  32'h0,         ALU,  32'h0,    32'd0, 32'd0, 32'h0000_7000,  1'b0, K_SEQ}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hold_i = 1'b0;
  logic [31:0] id_instr_i = '0, id_pc_i = '0, ex_instr_i = '0, ex_pc_i = '0;
  logic [31:0] ex_opa_i = '0, ex_opb_i = '0, ex_jr_tgt_i = '0;
  logic [31:0] fetch_pc_o;
  logic        pc_we_o, flush_ifid_o, flush_idex_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fetch_steer #(.RESET_PC(RST_PC)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold_i),
    .id_instr_i(id_instr_i), .id_pc_i(id_pc_i),
    .ex_instr_i(ex_instr_i), .ex_pc_i(ex_pc_i),
    .ex_opa_i(ex_opa_i), .ex_opb_i(ex_opb_i), .ex_jr_tgt_i(ex_jr_tgt_i),
    .fetch_pc_o(fetch_pc_o), .pc_we_o(pc_we_o),
    .flush_ifid_o(flush_ifid_o), .flush_idex_o(flush_idex_o)
  );

  function automatic logic [31:0] j_target(logic [31:0] ins, logic [31:0] pc);
    logic [31:0] p4 = pc + 32'd4;
    return {p4[31:28], ins[25:0], 2'b00};
  endfunction

  function automatic logic [31:0] b_target(logic [31:0] ins, logic [31:0] pc);
    return pc + 32'd4 + {{14{ins[15]}}, ins[15:0], 2'b00};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    hold_i = 1'b0; id_instr_i = NOP; id_pc_i = '0; ex_instr_i = NOP; ex_pc_i = '0;
    ex_opa_i = '0; ex_opb_i = '0; ex_jr_tgt_i = '0;
  endtask

  // called just after a falling edge
  task automatic apply(input vec_t v);
    logic [31:0] pc0, exp_pc;
    logic [2:0]  exp_ctl;
    string       req;
    req = $sformatf("%s", v.tag);
    hold_i = v.hold; id_instr_i = v.id_ins; id_pc_i = v.id_pc;
    ex_instr_i = v.ex_ins; ex_pc_i = v.ex_pc; ex_opa_i = v.a; ex_opb_i = v.b;
    ex_jr_tgt_i = v.jr;
    #1;
    pc0 = fetch_pc_o;
    case (v.kind)
      K_SEQ:   begin exp_pc = pc0 + 32'd4;                 exp_ctl = 3'b000; end
      K_HLD:   begin exp_pc = pc0;                         exp_ctl = 3'b000; end
      K_IDJ:   begin exp_pc = j_target(v.id_ins, v.id_pc); exp_ctl = 3'b110; end
      K_BR:    begin exp_pc = b_target(v.ex_ins, v.ex_pc); exp_ctl = 3'b111; end
      default: begin exp_pc = v.jr & ~32'd3;               exp_ctl = 3'b111; end
    endcase
    check(req, "we/ifid/idex", {29'd0, pc_we_o, flush_ifid_o, flush_idex_o}, {29'd0, exp_ctl});
    @(negedge clk_i);
    check(req, "fetch_pc", fetch_pc_o, exp_pc);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_bad++;
    $display("FAIL all watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    clear_inputs();
    repeat (3) @(negedge clk_i);
    // R1: reset values
    check("R1", "fetch_pc in reset", fetch_pc_o, RST_PC);
    check("R1", "flushes in reset", {30'd0, flush_ifid_o, flush_idex_o}, 32'd3);
    rst_ni = 1'b1;
    #1;
    check("R2", "flushes after release", {30'd0, flush_ifid_o, flush_idex_o}, 32'd0);
    @(negedge clk_i);
    check("R2", "first step", fetch_pc_o, RST_PC + 32'd4);

    for (int i = 0; i < NV; i++) apply(VECS[i]);

    // R1: reset mid-run with a pending register jump
    ex_instr_i = JRG; ex_jr_tgt_i = 32'h0000_9000;
    #2 rst_ni = 1'b0;
    #1;
    check("R1", "fetch_pc async reset", fetch_pc_o, RST_PC);
    check("R1", "flushes async reset", {30'd0, flush_ifid_o, flush_idex_o}, 32'd3);
    @(negedge clk_i);
    check("R1", "fetch_pc held in reset", fetch_pc_o, RST_PC);
    clear_inputs();
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11: every address seen stays word aligned
    check("R11", "alignment", {30'd0, fetch_pc_o[1:0]}, 32'd0);
    check("R2", "step after re-release", fetch_pc_o, RST_PC + 32'd4);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule